// File: doc/BRIEF.md
# MII Transmit Nibble Framer

This block turns one frame's worth of bytes from a MAC-side source into a 4-bit MII transmit stream. It runs entirely on the transmit clock that the PHY supplies. When a frame starts, it first emits the preamble and start-of-frame delimiter. It then splits each payload byte into two nibbles and, if the payload is short, adds zero bytes until the minimum frame size is reached. It closes the frame with a 32-bit CRC frame check sequence. Transmit enable frames exactly these nibbles.

The source offers bytes through a valid/ready handshake and marks the final byte with `s_last`. Ready is raised only in the cycle that puts a byte's low nibble on the wire. In that cycle the low nibble passes straight from `s_data` to `mii_txd`, and the high nibble is stored for the next cycle. The PHY's collision line is asynchronous. It passes through a two-stage synchroniser and sets a sticky flag, and that flag is cleared when the next frame begins.

The controller has seven states:
- IDLE goes to PREAMBLE when `s_valid` is high.
- PREAMBLE counts sixteen nibbles, then goes to DATA_LO.
- DATA_LO goes to DATA_HI on a handshake.
- DATA_HI goes back to DATA_LO if more bytes follow. After the last byte it goes to PAD_LO if fewer than 60 bytes have been sent, and to FCS otherwise.
- PAD_LO always goes to PAD_HI.
- PAD_HI goes to PAD_LO while the byte count is below 60, and to FCS once it reaches 60.
- FCS counts eight nibbles and returns to IDLE.

Top module: `mii_tx_framer`

## Requirements
- R1: After reset and between frames, `mii_txen` is 0, `mii_txd` is 4'h0 and `s_ready` is 0.
- R2: A frame opens with sixteen nibbles: fifteen of 4'h5 followed by one 4'hD. `mii_txen` rises in the same cycle as the first 4'h5.
- R3: Each payload byte is sent as bits 3:0 first and bits 7:4 in the next cycle. `mii_txd[0]` carries the least significant bit of each nibble. The source holds `s_valid` high from the first byte of a frame to its last.
- R4: `s_ready` is 1 only in the cycle that drives a payload byte's low nibble. That is never two cycles in a row, and never during preamble, padding, FCS or high nibbles.
- R5: When the source ends a frame after fewer than 60 bytes, zero bytes are appended until exactly 60 bytes precede the FCS.
- R6: The FCS is eight nibbles. They are the complement of a reflected CRC-32 (polynomial 0x04C11DB7, reflected constant 0xEDB88320, initial value 0xFFFFFFFF) computed over all payload and pad bytes, sent least significant nibble first.
- R7: `mii_txen` falls in the cycle right after the last FCS nibble. A frame therefore lasts 16 + 2·max(N,60) + 8 cycles with enable high, for N source bytes.
- R8: A collision pulse on `col_async` sets `col_seen` after the third rising clock edge, through two synchroniser stages and the flag register. The flag then stays set for the rest of the frame and after it.
- R9: `col_seen` is cleared at the rising edge where a new frame leaves IDLE.
- R10: Frames of 60 to 1514 source bytes are sent without padding. A new frame may start in the cycle right after the previous one returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock from the PHY |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| s_valid | input | 1 | Source byte valid |
| s_data | input | 8 | Source byte |
| s_last | input | 1 | Marks the final byte of the frame |
| s_ready | output | 1 | Byte accepted this cycle when high with s_valid |
| mii_txd | output | 4 | Transmit nibble to the PHY |
| mii_txen | output | 1 | Transmit enable to the PHY |
| col_async | input | 1 | Asynchronous collision indication from the PHY |
| col_seen | output | 1 | Sticky, synchronised collision flag |

## Verification
The assertions assume the source behaves well. It keeps `s_valid` high with each next byte ready once a frame has begun, so the state machine never waits in DATA_LO. It also never offers more than 1514 bytes. The bench's driver presents a new byte at the falling edge right after each handshake, and it drops `s_valid` only after the byte marked `s_last` has been taken. Frame lengths stay within 1 to 1514 bytes. The collision pulse is driven at a falling edge, so its synchronised arrival lands on a known rising edge.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_DLO,
        S_DHI,
        S_PLO,
        S_PHI,
        S_FCS
    } tx_state_e;

    localparam int PRE_NIBBLES = 16;
    localparam int FCS_NIBBLES = 8;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

endpackage

// File: rtl/mtx_sync.sv
module mtx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/mtx_crc.sv
module mtx_crc
    import mtx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] crc
);

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n)    crc <= CRC_SEED;
        else if (init) crc <= CRC_SEED;
        else if (en)   crc <= crc_byte(crc, data);
    end

endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer
    import mtx_pkg::*;
#(
    parameter int MIN_PAYLOAD = 60,
    parameter int MAX_PAYLOAD = 1514,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       s_valid,
    input  logic [7:0] s_data,
    input  logic       s_last,
    output logic       s_ready,
    output logic [3:0] mii_txd,
    output logic       mii_txen,
    input  logic       col_async,
    output logic       col_seen
);

    localparam int BCW = $clog2(MAX_PAYLOAD + 1);
    localparam logic [BCW-1:0] MIN_B = BCW'(MIN_PAYLOAD);
    localparam logic [BCW-1:0] MAX_B = BCW'(MAX_PAYLOAD);
    localparam logic [3:0] PRE_LAST = 4'(PRE_NIBBLES - 1);
    localparam logic [3:0] FCS_LAST = 4'(FCS_NIBBLES - 1);

    tx_state_e      state, nxt;
    logic [3:0]     cnt;
    logic [BCW-1:0] byte_cnt;
    logic [3:0]     hi_q;
    logic           last_q;
    logic [31:0]    crc;
    logic [31:0]    fcs_sh;
    logic           col_s;
    logic           start;
    logic           fire;
    logic           crc_en;
    logic [7:0]     crc_data;

    assign start    = (state == S_IDLE) && s_valid;
    assign fire     = s_ready && s_valid;
    assign crc_en   = fire || (state == S_PLO);
    assign crc_data = (state == S_PLO) ? 8'h00 : s_data;
    assign fcs_sh   = (~crc) >> {cnt[2:0], 2'b00};

    mtx_crc i_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (start),
        .en    (crc_en),
        .data  (crc_data),
        .crc   (crc)
    );

    mtx_sync #(.STAGES(SYNC_STAGES)) i_col_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (col_async),
        .q_sync  (col_s)
    );

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (s_valid) nxt = S_PRE;
            S_PRE:  if (cnt == PRE_LAST) nxt = S_DLO;
            S_DLO:  if (s_valid) nxt = S_DHI;
            S_DHI:  begin
                if (!last_q)             nxt = S_DLO;
                else if (byte_cnt < MIN_B) nxt = S_PLO;
                else                     nxt = S_FCS;
            end
            S_PLO:  nxt = S_PHI;
            S_PHI:  nxt = (byte_cnt < MIN_B) ? S_PLO : S_FCS;
            S_FCS:  if (cnt == FCS_LAST) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt      <= '0;
            byte_cnt <= '0;
            hi_q     <= '0;
            last_q   <= 1'b0;
            col_seen <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= (state != nxt) ? 4'd0 : cnt + 4'd1;
            if (start)
                byte_cnt <= '0;
            else if (fire || state == S_PLO)
                byte_cnt <= byte_cnt + 1'b1;
            if (fire) begin
                hi_q   <= s_data[7:4];
                last_q <= s_last;
            end
            if (start)
                col_seen <= 1'b0;
            else if (col_s && state != S_IDLE)
                col_seen <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        mii_txen = 1'b1;
        mii_txd  = 4'h0;
        s_ready  = 1'b0;
        unique case (state)
            S_IDLE: mii_txen = 1'b0;
            S_PRE:  mii_txd  = (cnt == PRE_LAST) ? 4'hD : 4'h5;
            S_DLO:  begin
                s_ready = 1'b1;
                mii_txd = s_data[3:0];
            end
            S_DHI:  mii_txd = hi_q;
            S_PLO:  mii_txd = 4'h0;
            S_PHI:  mii_txd = 4'h0;
            S_FCS:  mii_txd = fcs_sh[3:0];
            default: mii_txen = 1'b0;
        endcase
    end

    AST_EN_RISE_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mii_txen) |-> mii_txd == 4'h5); // R2
    AST_SRC_HOLDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_DLO |-> s_valid); // R3
    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready); // R4
    AST_PAD_MINIMUM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FCS && $past(state) != S_FCS) |-> byte_cnt >= MIN_B); // R5
    AST_EN_FALL_AFTER_FCS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mii_txen) |-> ($past(state) == S_FCS && $past(cnt) == FCS_LAST)); // R7
    AST_COL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (col_seen && !start) |=> col_seen); // R8
    AST_COL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !col_seen); // R9
    AST_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= MAX_B); // R10

endmodule

// File: tb/test_mii_tx_framer.sv
module test_mii_tx_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic [3:0] mii_txd;
    logic       mii_txen;
    logic       col_async = 1'b0;
    logic       col_seen;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] pay [0:1513];
    logic [3:0] nib [0:3199];
    logic       rdy [0:3199];
    int         n_nib;
    logic       first_col;

    always #5 clk = ~clk;

    mii_tx_framer i_mii_tx_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_last    (s_last),
        .s_ready   (s_ready),
        .mii_txd   (mii_txd),
        .mii_txen  (mii_txen),
        .col_async (col_async),
        .col_seen  (col_seen)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int len);
        logic [31:0] c;
        logic [7:0] b;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < len; i++) begin
            b = pay[i];
            for (int j = 0; j < 8; j++) begin
                logic fb;
                fb = c[0] ^ b[j];
                c = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c;
    endfunction

    task automatic drive(input int len);
        int i;
        bit hot;
        i = 0;
        hot = 1'b0;
        s_valid = 1'b1;
        s_data = pay[0];
        s_last = (len == 1);
        while (i < len) begin
            @(negedge clk);
            if (hot) begin
                i++;
                if (i < len) begin
                    s_data = pay[i];
                    s_last = (i == len - 1);
                end else begin
                    s_valid = 1'b0;
                    s_last = 1'b0;
                end
            end
            hot = s_ready;
        end
    endtask

    task automatic collect();
        n_nib = 0;
        @(negedge clk);
        while (!mii_txen) @(negedge clk);
        first_col = col_seen;
        while (mii_txen) begin
            nib[n_nib] = mii_txd;
            rdy[n_nib] = s_ready;
            n_nib++;
            @(negedge clk);
        end
    endtask

    // sends len bytes, pads the reference copy and checks the wire image
    task automatic run_frame(input int len, input int seed);
        int plen, exp_n, e_pre, e_dat, e_pad, e_rdy, e_fcs;
        logic [31:0] fcs;
        longint a_dat, x_dat;
        for (int i = 0; i < len; i++) pay[i] = 8'((seed + i * 37) ^ (i >> 2));
        plen = (len < 60) ? 60 : len;
        for (int i = len; i < plen; i++) pay[i] = 8'h00;
        fork
            drive(len);
            collect();
        join
        exp_n = 16 + 2 * plen + 8;
        chk(n_nib == exp_n, "R7 enable length", n_nib, exp_n);
        e_pre = 0;
        for (int i = 0; i < 16; i++)
            if (nib[i] !== ((i == 15) ? 4'hD : 4'h5)) e_pre++;
        chk(e_pre == 0, "R2 preamble nibbles", e_pre, 0);
        e_dat = 0; e_pad = 0; a_dat = 0; x_dat = 0;
        for (int i = 0; i < plen && (16 + 2 * i + 1) < n_nib; i++) begin
            if (nib[16 + 2 * i] !== pay[i][3:0] || nib[17 + 2 * i] !== pay[i][7:4]) begin
                if (i < len) begin
                    if (e_dat == 0) begin
                        a_dat = {nib[17 + 2 * i], nib[16 + 2 * i]};
                        x_dat = pay[i];
                    end
                    e_dat++;
                end else e_pad++;
            end
        end
        chk(e_dat == 0, "R3 byte nibble order", a_dat, x_dat);
        chk(e_pad == 0, "R5 zero padding", e_pad, 0);
        e_rdy = 0;
        for (int k = 0; k < n_nib; k++)
            if (rdy[k] !== ((k >= 16) && (k < 16 + 2 * len) && ((k % 2) == 0))) e_rdy++;
        chk(e_rdy == 0, "R4 ready phase", e_rdy, 0);
        fcs = ~ref_crc(plen);
        e_fcs = 0;
        for (int k = 0; k < 8; k++)
            if ((16 + 2 * plen + k) >= n_nib || nib[16 + 2 * plen + k] !== fcs[4 * k +: 4]) e_fcs++;
        chk(e_fcs == 0, "R6 fcs nibbles", e_fcs, 0);
        chk(mii_txen == 1'b0 && mii_txd == 4'h0 && s_ready == 1'b0,
            "R1 idle after frame", {mii_txen, mii_txd, s_ready}, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(mii_txen == 1'b0 && mii_txd == 4'h0 && s_ready == 1'b0 && col_seen == 1'b0,
            "R1 reset state", {mii_txen, mii_txd, s_ready, col_seen}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mii_txen == 1'b0 && mii_txd == 4'h0, "R1 idle after reset", {mii_txen, mii_txd}, 0);
    endtask

    task automatic t_short_pad();
        run_frame(1, 8'h3C);   // R5 heavy padding
        run_frame(17, 8'hA1);  // R5 partial padding
    endtask

    task automatic t_boundary();
        run_frame(60, 8'h11);  // R10 exactly at minimum
        run_frame(61, 8'h5A);  // R10 just above
    endtask

    task automatic t_long();
        run_frame(1514, 8'h77); // R10 maximum
    endtask

    task automatic t_collision();
        fork
            run_frame(80, 8'h42);
            begin
                repeat (30) @(negedge clk);
                chk(col_seen == 1'b0, "R8 flag low before pulse", col_seen, 0);
                col_async = 1'b1;
                @(negedge clk);
                col_async = 1'b0;
                @(negedge clk);
                chk(col_seen == 1'b0, "R8 flag after two edges", col_seen, 0);
                @(negedge clk);
                chk(col_seen == 1'b1, "R8 flag after third edge", col_seen, 1);
            end
        join
        chk(col_seen == 1'b1, "R8 flag sticky after frame", col_seen, 1);
        run_frame(64, 8'h09);  // R9 back-to-back with cleared flag
        chk(first_col == 1'b0, "R9 flag cleared at frame start", first_col, 0);
    endtask

    initial begin
        t_reset();
        t_short_pad();
        t_boundary();
        t_long();
        t_collision();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule